// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for a single SDRAM read or write burst. A controller presents a starting column, a burst length code and an ordering bit together with a one-cycle start strobe. From the next clock on, the block emits one column address per cycle with a valid flag. It marks the final beat of a fixed-length burst and stops by itself after that beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside a naturally aligned block of columns. The column bits above the block size never change, and the low bits either count upward with wrap-around or are the start's low bits XORed with a beat index. A full-page burst walks all 256 columns of the row, wraps from 255 to 0, and runs until a terminate strobe arrives. A terminate strobe ends any burst after the beat currently shown. A fresh start during a burst replaces it at once. A start with an unsupported setting raises an error flag for one cycle and issues no address.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_o, last_o and err_o are low and col_o is 0.
- R2: A legal start sampled at clock edge n puts the unchanged start column on col_o, with valid_o high, in the cycle after edge n.
- R3: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8; valid_o stays high over consecutive cycles for exactly that many beats and then falls.
- R4: In a 2-, 4- or 8-beat burst, the column bits at and above bit 1, 2 or 3 respectively equal those of the start column on every beat.
- R5: With order bit ilv_i = 0, beat i carries the start's low bits plus i, taken modulo the burst length (start 5, length 8: 5,6,7,0,1,2,3,4).
- R6: With ilv_i = 1, beat i carries the start's low bits XOR i (start 5, length 8: 5,4,7,6,1,0,3,2).
- R7: With length code 3'b000, the order bit has no effect, and the single beat is the start column.
- R8: Length code 3'b111 with ilv_i = 0 is a full-page burst: the column increments by one each beat, goes from 255 to 0, and continues until terminated.
- R9: A start with ilv_i = 1 and code 3'b111, or with a reserved code 3'b100, 3'b101 or 3'b110, gives err_o high for exactly the next cycle and no valid beat.
- R10: term_i sampled high at the edge that ends a shown beat makes that beat the last one; valid_o is low in the following cycle unless a start was also sampled.
- R11: A legal start sampled during a burst discards the old burst, and the next beat is the new start column; start has priority over term_i.
- R12: last_o is high exactly on the final beat of a 1-, 2-, 4- or 8-beat burst and is never high in a full-page burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a burst |
| start_col_i | input | 8 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code (see R3, R8, R9) |
| ilv_i | input | 1 | Ordering: 0 counting, 1 XOR-interleaved |
| term_i | input | 1 | Ends the running burst after the shown beat |
| col_o | output | 8 | Column address of the current beat, 0 when idle |
| valid_o | output | 1 | A beat is present on col_o |
| last_o | output | 1 | The current beat is the final one of a fixed burst |
| err_o | output | 1 | Previous start had an unsupported setting |

## Verification
The hardest case to reach from the ports is the full-page wrap. A run has to start near the top of the row, and the terminate strobe must land on one exact beat more than 255 cycles later, so that the step from 255 to 0 and the clean end can both be seen. The bench starts a full-page burst at column 250, counts 260 beats and then drives terminate, with every beat scored against a model-computed queue. A burst that is restarted midway and a burst that is terminated before its natural end are driven in the same way, by timing the second strobe against the beat counter.

// File: rtl/burst_col_pkg.sv
// Package: shared length-code encodings for the burst column generator.
// Assumes a 3-bit length code; the low two bits give log2 of fixed lengths.
package burst_col_pkg;
    localparam int          LEN_CODE_W = 3;
    localparam logic [2:0]  LEN_ONE    = 3'b000;
    localparam logic [2:0]  LEN_PAGE   = 3'b111;
endpackage

// File: rtl/burst_cfg_decode.sv
// Module: burst_cfg_decode
// Turns a length code and order bit into a mask of the varying column bits,
// a full-page flag, the effective order bit and a legality flag.
// Assumes COL_W >= 3 so that an 8-beat block fits inside a row.
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o,
    output logic                  ilv_o,
    output logic                  legal_o
);
    // Classify the code: full page, and whether the combination is supported.
    always_comb begin
        full_o  = (len_code_i == LEN_PAGE);
        legal_o = !len_code_i[LEN_CODE_W-1] || (full_o && !ilv_i);
        ilv_o   = ilv_i && (len_code_i != LEN_ONE) && !full_o;
    end

    // One mask bit per column bit: set when that bit moves within the burst.
    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        assign mask_o[g] = full_o || (int'(len_code_i[1:0]) > g);
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Tracks whether a burst is running and which beat it is on.
// Assumes mask_i/full_i are held stable by the parent for the whole burst.
module burst_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             kill_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic             final_o
);
    logic             active_q;
    logic [COL_W-1:0] beat_q;

    // Final beat of a fixed burst: the index has reached the block size minus one.
    always_comb begin
        final_o = active_q && !full_i && (beat_q == mask_i);
    end

    // Advance or stop the beat index; a new start takes priority over stopping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (kill_i) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (term_i || final_o) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
endmodule

// File: rtl/burst_addr_map.sv
// Module: burst_addr_map
// Combinational: forms the column for a beat from base, beat index and mask.
// Bits outside the mask come from the base; bits inside come from either a
// sum (counting order) or an XOR (interleaved order) of base and beat.
module burst_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum_w;
    logic [COL_W-1:0] xor_w;

    // Both candidate orderings; the sum carries past the mask but is cut below.
    always_comb begin
        sum_w = base_i + beat_i;
        xor_w = base_i ^ beat_i;
    end

    // Per-bit select between fixed base bit and the chosen moving bit.
    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        assign col_o[g] = mask_i[g] ? (ilv_i ? xor_w[g] : sum_w[g]) : base_i[g];
    end
endmodule

// File: rtl/burst_colgen.sv
// Module: burst_colgen (top)
// Emits one column address per cycle for an SDRAM burst of 1/2/4/8 beats or
// a full page. Captures the burst setting on start, flags unsupported
// settings for one cycle, and honours an early terminate.
// Assumes start_i and term_i are single-cycle synchronous strobes.
module burst_colgen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic             dec_legal;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic             err_q;

    logic             load_w;
    logic             kill_w;
    logic             active_w;
    logic             final_w;
    logic [COL_W-1:0] beat_w;
    logic [COL_W-1:0] map_col;

    burst_cfg_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .mask_o     (dec_mask),
        .full_o     (dec_full),
        .ilv_o      (dec_ilv),
        .legal_o    (dec_legal)
    );

    // Split the start strobe into an accepted start and a rejected one.
    always_comb begin
        load_w = start_i && dec_legal;
        kill_w = start_i && !dec_legal;
    end

    // Hold the burst setting captured at start, and the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= kill_w;
            if (load_w) begin
                base_q <= start_col_i;
                mask_q <= dec_mask;
                full_q <= dec_full;
                ilv_q  <= dec_ilv;
            end
        end
    end

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .kill_i   (kill_w),
        .term_i   (term_i),
        .mask_i   (mask_q),
        .full_i   (full_q),
        .active_o (active_w),
        .beat_o   (beat_w),
        .final_o  (final_w)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (base_q),
        .beat_i (beat_w),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (map_col)
    );

    // Drive the outputs; the column reads zero while no burst is running.
    always_comb begin
        col_o   = active_w ? map_col : '0;
        valid_o = active_w;
        last_o  = final_w;
        err_o   = err_q;
    end
endmodule

// File: rtl/burst_colgen_chk.sv
// Module: burst_colgen_chk
// Port-level protocol checks for burst_colgen, attached with bind below.
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    // R2
    start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (err_o || (valid_o && col_o == $past(start_col_i))));

    // R9
    err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    // R10
    term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !start_i) |=> !valid_o);

    // R12
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R3
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R3
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !term_i && !start_i) |=> valid_o);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/sim_burst_colgen.sv
// Scoreboard bench: driver tasks queue expected beats, a monitor compares.
module sim_burst_colgen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       err_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] q_col[$];
    logic       q_last[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    // Model: number of beats of a fixed code, 0 for full page.
    function automatic int ref_len(input logic [2:0] code);
        return (code == 3'b111) ? 0 : (1 << code[1:0]);
    endfunction

    // Model: column of beat i from the requirements (R4, R5, R6, R7, R8).
    function automatic logic [7:0] ref_col(input logic [7:0] base, input logic [2:0] code,
                                           input logic ilv, input int i);
        logic [7:0] m;
        logic [7:0] low;
        m   = (code == 3'b111) ? 8'hFF : 8'(ref_len(code) - 1);
        low = (ilv && code != 3'b000) ? (base ^ 8'(i)) : (base + 8'(i));
        return (base & ~m) | (low & m);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_beats(input logic [7:0] base, input logic [2:0] code,
                              input logic ilv, input int count, input string tag);
        for (int i = 0; i < count; i++) begin
            q_col.push_back(ref_col(base, code, ilv, i));
            q_last.push_back(code != 3'b111 && i == ref_len(code) - 1);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drive_start(input logic [7:0] base, input logic [2:0] code, input logic ilv);
        start_i = 1'b1; start_col_i = base; len_code_i = code; ilv_i = ilv;
    endtask

    task automatic drain();
        while (q_col.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_burst(input logic [7:0] base, input logic [2:0] code,
                             input logic ilv, input string tag);
        push_beats(base, code, ilv, ref_len(code), tag);
        @(negedge clk); drive_start(base, code, ilv);
        @(negedge clk); start_i = 1'b0;
        drain();
    endtask

    task automatic run_term(input logic [7:0] base, input logic [2:0] code,
                            input logic ilv, input int k, input string tag);
        push_beats(base, code, ilv, k, tag);
        @(negedge clk); drive_start(base, code, ilv);
        @(negedge clk); start_i = 1'b0;
        repeat (k - 1) @(negedge clk);
        term_i = 1'b1;
        @(negedge clk); term_i = 1'b0;
        drain();
    endtask

    task automatic run_restart(input logic [7:0] a_base, input logic [2:0] a_code, input int j,
                               input logic [7:0] b_base, input logic [2:0] b_code,
                               input logic b_ilv, input string tag);
        push_beats(a_base, a_code, 1'b0, j, tag);
        push_beats(b_base, b_code, b_ilv, ref_len(b_code), tag);
        @(negedge clk); drive_start(a_base, a_code, 1'b0);
        @(negedge clk); start_i = 1'b0;
        repeat (j - 1) @(negedge clk);
        drive_start(b_base, b_code, b_ilv);
        term_i = 1'b1;
        @(negedge clk); start_i = 1'b0; term_i = 1'b0;
        drain();
    endtask

    task automatic run_err(input logic [2:0] code, input logic ilv, input string tag);
        @(negedge clk); drive_start(8'h3C, code, ilv);
        @(negedge clk); start_i = 1'b0;
        check(err_o === 1'b1 && valid_o === 1'b0, tag, {err_o, valid_o}, 2'b10);
        @(negedge clk);
        check(err_o === 1'b0 && valid_o === 1'b0, tag, {err_o, valid_o}, 2'b00);
    endtask

    // Monitor: every valid beat must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && valid_o === 1'b1) begin
            if (q_col.size() == 0) begin
                check(1'b0, "R3 R10 unexpected beat", col_o, 0);
            end else begin
                logic [7:0] ec;
                logic       el;
                string      et;
                ec = q_col.pop_front();
                el = q_last.pop_front();
                et = q_tag.pop_front();
                check(col_o === ec && last_o === el, et, {last_o, col_o}, {el, ec});
            end
        end
    end

    // Watchdog: a hung run counts as one failed check and still summarises.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs idle in reset and right after it.
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0 && col_o === 8'h00,
              "R1 reset", {valid_o, last_o, err_o, col_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0 && err_o === 1'b0, "R1 after reset", {valid_o, err_o}, 0);

        run_burst(8'h5A, 3'b000, 1'b0, "R2 R3 R12 len1");
        run_burst(8'h05, 3'b001, 1'b0, "R3 R4 R5 R12 len2");
        run_burst(8'h2D, 3'b010, 1'b0, "R3 R4 R5 R12 len4");
        run_burst(8'hA5, 3'b011, 1'b0, "R3 R4 R5 R12 len8 seq");
        run_burst(8'h05, 3'b011, 1'b1, "R6 R4 len8 ilv");
        run_burst(8'h7E, 3'b010, 1'b1, "R6 R4 len4 ilv");
        run_burst(8'hB3, 3'b001, 1'b1, "R6 len2 ilv");
        run_burst(8'h93, 3'b000, 1'b1, "R7 len1 ilv ignored");

        run_term(8'd250, 3'b111, 1'b0, 260, "R8 R12 full page wrap");
        run_term(8'h02, 3'b011, 1'b0, 3, "R10 early term len8");
        run_term(8'h41, 3'b001, 1'b1, 1, "R10 term first beat");

        run_restart(8'h10, 3'b011, 3, 8'h47, 3'b010, 1'b1, "R11 restart into ilv4");
        run_restart(8'hF0, 3'b111, 5, 8'h09, 3'b001, 1'b0, "R11 restart from page");

        run_err(3'b111, 1'b1, "R9 page with ilv");
        run_err(3'b100, 1'b0, "R9 reserved 100");
        run_err(3'b110, 1'b1, "R9 reserved 110");
        run_burst(8'h66, 3'b010, 1'b0, "R9 recovery after error");

        check(q_col.size() == 0, "R3 queue empty at end", q_col.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule